// File: doc/BRIEF.md
# Trigger-Level Byte FIFO Interrupt Unit

This block sits between a register port and the bus engine of a serial controller. It holds two byte FIFOs. Software fills the transmit FIFO through a data register and the engine drains it. The engine fills the receive FIFO and software drains it through a second data register. Each FIFO has its own enable bit and its own software-programmed trigger level. When the transmit fill drops to its trigger, or the receive fill climbs to its trigger, the block latches an interrupt cause.

A short receive tail may never reach the receive trigger. An idle counter catches that case: it raises a trailing cause after bytes have waited unread and unchanged for a programmed number of cycles. Pushing into a full FIFO or popping from an empty one drops the access and latches an error cause. All causes collect in a sticky status word that is cleared by writing ones. A mask combines three of them into the single interrupt line.

Top module: `trig_fifo_irq`

## Requirements
- R1: After reset both FIFOs are empty, the FIFO status word reads 0x0100_0100, the interrupt status reads 0 and `irq` is low.
- R2: Register word index 0 holds the FIFO control: bit 0 enables the RX FIFO, bit 1 enables the TX FIFO, the RX trigger sits in bits 10:4 and the TX trigger in bits 22:16. A disabled FIFO is held empty, ignores pushes and pops, and raises no cause.
- R3: Each FIFO returns bytes in the order they entered. A write to word index 5 pushes into TX. `engTxPop` removes the byte shown on `engTxData`. `engRxPush` stores `engRxData`. A read of word index 6 returns the oldest RX byte in bits 7:0 and removes it.
- R4: Word index 4 is the FIFO status: TX level in bits 6:0, TX full at bit 7, TX empty at bit 8, RX level in bits 22:16, RX full at bit 23, RX empty at bit 24.
- R5: A push into a full FIFO is dropped and sets status bit 3 (TX overrun) or bit 5 (RX overrun).
- R6: A pop from an empty FIFO is dropped, returns 0, and sets status bit 2 (TX underrun) or bit 4 (RX underrun).
- R7: While TX is enabled and its level is at or below the TX trigger, status bit 0 is set.
- R8: While RX is enabled and its level is at or above the RX trigger, status bit 1 is set.
- R9: Word index 1 bits 3:0 hold the idle limit L. The idle count runs while RX is enabled, non-empty and below its trigger, and any RX push or pop attempt resets it to zero. Status bit 6 is set at the L-th clock edge after the last such access. L = 0 disables the timer.
- R10: Interrupt status is word index 3, seven sticky bits. Writing 1 to a bit clears it. A cause present in the same cycle keeps the bit set.
- R11: Word index 2 holds the mask in bits 0, 1 and 6, and all other bits read as 0. `irq` is high when any masked status bit among 0, 1 and 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Register word index |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdEn | input | 1 | Register read strobe (pops RX at index 6) |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| engTxPop | input | 1 | Engine takes a TX byte |
| engTxData | output | 8 | Oldest TX byte, 0 when empty |
| engRxPush | input | 1 | Engine delivers an RX byte |
| engRxData | input | 8 | RX byte from the engine |
| irq | output | 1 | Masked interrupt request |

## Verification
The trailing cause is the hardest condition to produce. It needs the RX FIFO enabled, holding fewer bytes than its trigger, and left alone for exactly the programmed number of edges. The stimulus sets a trigger of 4 and a limit of 5, pushes one byte, and then samples the interrupt line once before the limit expires and once after it. Overrun at full depth and sticky causes that survive a write-one clear are also reached only through long sequences, so directed loops fill each FIFO to one byte past full.

// File: rtl/tfi_pkg.sv
package tfi_pkg;
  localparam int LVL_W = 7;
  localparam int STAT_W = 7;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_TRAIL = 3'd1;
  localparam logic [2:0] A_INTEN = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_FSTAT = 3'd4;
  localparam logic [2:0] A_TXD   = 3'd5;
  localparam logic [2:0] A_RXD   = 3'd6;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
  } fifoStrobe_t;

  typedef struct packed {
    logic [LVL_W-1:0] txLevel;
    logic [LVL_W-1:0] rxLevel;
    logic             txFull;
    logic             txEmpty;
    logic             rxFull;
    logic             rxEmpty;
    logic [7:0]       txHead;
    logic [7:0]       rxHead;
  } fifoView_t;
endpackage

// File: rtl/tfi_fifo.sv
module tfi_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     push,
  input  logic                     pop,
  input  logic [WIDTH-1:0]         wrData,
  output logic [WIDTH-1:0]         rdData,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wrPtr] <= wrData;
  end

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign count  = cnt;
  assign rdData = empty ? '0 : mem[rdPtr];
endmodule

// File: rtl/tfi_datapath.sv
module tfi_datapath import tfi_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  fifoStrobe_t strobe,
  input  logic [7:0]  txWrData,
  input  logic [7:0]  rxWrData,
  output fifoView_t   view
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] txCount, rxCount;

  tfi_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txFifo (
    .clk(clk), .rst_n(rst_n), .clr(strobe.txClr),
    .push(strobe.txPush), .pop(strobe.txPop), .wrData(txWrData),
    .rdData(view.txHead), .count(txCount),
    .full(view.txFull), .empty(view.txEmpty)
  );

  tfi_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxFifo (
    .clk(clk), .rst_n(rst_n), .clr(strobe.rxClr),
    .push(strobe.rxPush), .pop(strobe.rxPop), .wrData(rxWrData),
    .rdData(view.rxHead), .count(rxCount),
    .full(view.rxFull), .empty(view.rxEmpty)
  );

  assign view.txLevel = LVL_W'(txCount);
  assign view.rxLevel = LVL_W'(rxCount);
endmodule

// File: rtl/tfi_ctrl.sv
module tfi_ctrl import tfi_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  input  logic              regRdEn,
  output logic [31:0]       regRdData,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  fifoView_t         view,
  output fifoStrobe_t       strobe,
  output logic [STAT_W-1:0] intStat,
  output logic [2:0]        irqMask,
  output logic              irq
);
  logic             rxEn, txEn;
  logic [LVL_W-1:0] rxTrig, txTrig;
  logic [3:0]       trailLimit, trailCnt;
  logic [STAT_W-1:0] events, w1c;
  logic txPushReq, txPopReq, rxPushReq, rxPopReq;
  logic trailWait, rxTouch, trailHit;

  assign txPushReq = regWrEn && (regAddr == A_TXD) && txEn;
  assign rxPopReq  = regRdEn && (regAddr == A_RXD) && rxEn;
  assign txPopReq  = engTxPop && txEn;
  assign rxPushReq = engRxPush && rxEn;

  always_comb begin
    strobe.txPush = txPushReq && !view.txFull;
    strobe.txPop  = txPopReq  && !view.txEmpty;
    strobe.rxPush = rxPushReq && !view.rxFull;
    strobe.rxPop  = rxPopReq  && !view.rxEmpty;
    strobe.txClr  = !txEn;
    strobe.rxClr  = !rxEn;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxEn       <= 1'b0;
      txEn       <= 1'b0;
      rxTrig     <= '0;
      txTrig     <= '0;
      trailLimit <= '0;
      irqMask    <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        A_CTRL: begin
          rxEn   <= regWrData[0];
          txEn   <= regWrData[1];
          rxTrig <= regWrData[10:4];
          txTrig <= regWrData[22:16];
        end
        A_TRAIL: trailLimit <= regWrData[3:0];
        A_INTEN: irqMask    <= {regWrData[6], regWrData[1], regWrData[0]};
        default: ;
      endcase
    end
  end

  // trailing idle timer
  assign trailWait = rxEn && !view.rxEmpty && (view.rxLevel < rxTrig);
  assign rxTouch   = engRxPush || (regRdEn && (regAddr == A_RXD));
  assign trailHit  = trailWait && !rxTouch && (trailLimit != 4'd0) &&
                     ({1'b0, trailCnt} + 5'd1 == {1'b0, trailLimit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     trailCnt <= '0;
    else if (!trailWait || rxTouch) trailCnt <= '0;
    else if (trailCnt != trailLimit) trailCnt <= trailCnt + 1'b1;
  end

  // sticky cause collection
  always_comb begin
    events[0] = txEn && (view.txLevel <= txTrig);
    events[1] = rxEn && (view.rxLevel >= rxTrig);
    events[2] = txPopReq  && view.txEmpty;
    events[3] = txPushReq && view.txFull;
    events[4] = rxPopReq  && view.rxEmpty;
    events[5] = rxPushReq && view.rxFull;
    events[6] = trailHit;
    w1c = (regWrEn && (regAddr == A_STAT)) ? regWrData[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intStat <= '0;
    else        intStat <= (intStat & ~w1c) | events;
  end

  assign irq = |({intStat[6], intStat[1], intStat[0]} & irqMask);

  always_comb begin
    case (regAddr)
      A_CTRL:  regRdData = {9'b0, txTrig, 5'b0, rxTrig, 2'b0, txEn, rxEn};
      A_TRAIL: regRdData = {28'b0, trailLimit};
      A_INTEN: regRdData = {25'b0, irqMask[2], 4'b0, irqMask[1], irqMask[0]};
      A_STAT:  regRdData = {25'b0, intStat};
      A_FSTAT: regRdData = {7'b0, view.rxEmpty, view.rxFull, view.rxLevel,
                            7'b0, view.txEmpty, view.txFull, view.txLevel};
      A_RXD:   regRdData = {24'b0, view.rxHead};
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/trig_fifo_irq.sv
module trig_fifo_irq import tfi_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  input  logic        regRdEn,
  output logic [31:0] regRdData,
  input  logic        engTxPop,
  output logic [7:0]  engTxData,
  input  logic        engRxPush,
  input  logic [7:0]  engRxData,
  output logic        irq
);
  fifoStrobe_t       strobe;
  fifoView_t         view;
  logic [STAT_W-1:0] intStat;
  logic [2:0]        irqMask;

  tfi_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .engTxPop(engTxPop), .engRxPush(engRxPush), .view(view),
    .strobe(strobe), .intStat(intStat), .irqMask(irqMask), .irq(irq)
  );

  tfi_datapath #(.DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .txWrData(regWrData[7:0]), .rxWrData(engRxData), .view(view)
  );

  assign engTxData = view.txHead;
endmodule

// File: rtl/tfi_checker.sv
module tfi_checker import tfi_pkg::*; #(
  parameter int DEPTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input fifoView_t         view,
  input fifoStrobe_t       strobe,
  input logic [STAT_W-1:0] intStat,
  input logic [2:0]        irqMask,
  input logic              irq,
  input logic              regWrEn,
  input logic [2:0]        regAddr
);
  logic statWr;
  assign statWr = regWrEn && (regAddr == A_STAT);

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (view.txLevel <= LVL_W'(DEPTH)) && (view.rxLevel <= LVL_W'(DEPTH))); // R5

  AST_TX_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    view.txFull |=> view.txLevel <= $past(view.txLevel)); // R5

  AST_RX_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    view.rxFull |=> view.rxLevel <= $past(view.rxLevel)); // R5

  AST_EMPTY_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    view.rxEmpty |=> view.rxLevel <= LVL_W'(1)); // R6

  AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rxClr |=> view.rxEmpty); // R2

  AST_TRAIL_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (view.rxEmpty && !intStat[6]) |=> !intStat[6]); // R9

  AST_STICKY_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    !statWr |=> ((intStat & $past(intStat)) == $past(intStat))); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irqMask == 3'b000) |-> !irq); // R11
endmodule

bind trig_fifo_irq tfi_checker #(.DEPTH(DEPTH)) u_tfi_checker (
  .clk(clk), .rst_n(rst_n), .view(view), .strobe(strobe),
  .intStat(intStat), .irqMask(irqMask), .irq(irq),
  .regWrEn(regWrEn), .regAddr(regAddr)
);

// File: tb/trig_fifo_irq_bench.sv
module trig_fifo_irq_bench;
  localparam int DEPTH = 16;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_TXP = 3'd2,
                         OP_RXQ = 3'd3, OP_IRQ = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 35;
  localparam vec_t VECS [NVEC] = '{
    '{OP_WR,  3'd0, 32'h0002_0033, 32'h0,          4'd2},  // R2 both on, rx trig 3, tx trig 2
    '{OP_WR,  3'd5, 32'h0000_00A1, 32'h0,          4'd3},  // R3
    '{OP_WR,  3'd5, 32'h0000_00B2, 32'h0,          4'd3},
    '{OP_WR,  3'd5, 32'h0000_00C3, 32'h0,          4'd3},
    '{OP_RD,  3'd4, 32'h0,         32'h0100_0003,  4'd4},  // R4
    '{OP_WR,  3'd3, 32'h0000_007F, 32'h0,          4'd10}, // R10
    '{OP_RD,  3'd3, 32'h0,         32'h0,          4'd10},
    '{OP_TXP, 3'd0, 32'h0,         32'h0000_00A1,  4'd3},
    '{OP_RD,  3'd4, 32'h0,         32'h0100_0002,  4'd4},
    '{OP_RD,  3'd3, 32'h0,         32'h0000_0001,  4'd7},  // R7
    '{OP_TXP, 3'd0, 32'h0,         32'h0000_00B2,  4'd3},
    '{OP_TXP, 3'd0, 32'h0,         32'h0000_00C3,  4'd3},
    '{OP_TXP, 3'd0, 32'h0,         32'h0,          4'd6},  // R6
    '{OP_RD,  3'd4, 32'h0,         32'h0100_0100,  4'd6},
    '{OP_RD,  3'd3, 32'h0,         32'h0000_0005,  4'd6},
    '{OP_RXQ, 3'd0, 32'h0000_0011, 32'h0,          4'd3},
    '{OP_RXQ, 3'd0, 32'h0000_0022, 32'h0,          4'd3},
    '{OP_RXQ, 3'd0, 32'h0000_0033, 32'h0,          4'd3},
    '{OP_RD,  3'd4, 32'h0,         32'h0003_0100,  4'd4},
    '{OP_RD,  3'd3, 32'h0,         32'h0000_0007,  4'd8},  // R8
    '{OP_RD,  3'd6, 32'h0,         32'h0000_0011,  4'd3},
    '{OP_RD,  3'd6, 32'h0,         32'h0000_0022,  4'd3},
    '{OP_RD,  3'd6, 32'h0,         32'h0000_0033,  4'd3},
    '{OP_RD,  3'd6, 32'h0,         32'h0,          4'd6},
    '{OP_RD,  3'd3, 32'h0,         32'h0000_0017,  4'd6},
    '{OP_WR,  3'd3, 32'h0000_0017, 32'h0,          4'd10},
    '{OP_RD,  3'd3, 32'h0,         32'h0000_0001,  4'd10}, // cause still present
    '{OP_WR,  3'd2, 32'h0000_0001, 32'h0,          4'd11}, // R11
    '{OP_IRQ, 3'd0, 32'h0,         32'h1,          4'd11},
    '{OP_WR,  3'd2, 32'h0000_0002, 32'h0,          4'd11},
    '{OP_IRQ, 3'd0, 32'h0,         32'h0,          4'd11},
    '{OP_WR,  3'd2, 32'hFFFF_FFFF, 32'h0,          4'd11},
    '{OP_RD,  3'd2, 32'h0,         32'h0000_0043,  4'd11},
    '{OP_WR,  3'd2, 32'h0,         32'h0,          4'd11},
    '{OP_IRQ, 3'd0, 32'h0,         32'h0,          4'd11}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic        engTxPop = 1'b0;
  logic [7:0]  engTxData;
  logic        engRxPush = 1'b0;
  logic [7:0]  engRxData = '0;
  logic        irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  trig_fifo_irq #(.DEPTH(DEPTH)) u_trig_fifo_irq (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .engTxPop(engTxPop), .engTxData(engTxData), .engRxPush(engRxPush),
    .engRxData(engRxData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic endCycle();
    @(posedge clk);
    #1;
    regWrEn = 1'b0; regRdEn = 1'b0; engTxPop = 1'b0; engRxPush = 1'b0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    endCycle();
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 v = regRdData;
    endCycle();
  endtask

  task automatic txPop(output logic [7:0] v);
    @(negedge clk);
    engTxPop = 1'b1;
    #1 v = engTxData;
    endCycle();
  endtask

  task automatic rxPush(input logic [7:0] d);
    @(negedge clk);
    engRxData = d; engRxPush = 1'b1;
    endCycle();
  endtask

  task automatic irqSample(output logic v);
    @(negedge clk);
    #1 v = irq;
    endCycle();
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  b;
    logic        q;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    regRead(3'd4, v); check("R1 fifo status", v, 32'h0100_0100);
    regRead(3'd3, v); check("R1 int status", v, 32'h0);
    regRead(3'd0, v); check("R1 control", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_WR:  regWrite(VECS[i].addr, VECS[i].data);
        OP_RD:  begin regRead(VECS[i].addr, v); check(tag, v, VECS[i].exp); end
        OP_TXP: begin txPop(b); check(tag, {24'b0, b}, VECS[i].exp); end
        OP_RXQ: rxPush(VECS[i].data[7:0]);
        default: begin irqSample(q); check(tag, {31'b0, q}, VECS[i].exp); end
      endcase
    end

    // R5 TX overrun at full depth
    regWrite(3'd0, 32'h0000_0003);
    regWrite(3'd3, 32'h0000_007F);
    for (int i = 0; i <= DEPTH; i++) regWrite(3'd5, 32'(i + 1));
    regRead(3'd4, v); check("R5 tx full status", v, 32'h0100_0090);
    regRead(3'd3, v); check("R5 tx overrun bit3", v & 32'h28, 32'h08);
    for (int i = 0; i < DEPTH; i++) begin
      txPop(b); check("R3 tx order after overrun", {24'b0, b}, 32'(i + 1));
    end

    // R5 RX overrun at full depth
    for (int i = 0; i <= DEPTH; i++) rxPush(8'(8'h40 + i));
    regRead(3'd4, v); check("R5 rx full status", v, 32'h0090_0100);
    regRead(3'd3, v); check("R5 rx overrun bit5", v & 32'h20, 32'h20);
    for (int i = 0; i < DEPTH; i++) begin
      regRead(3'd6, v); check("R3 rx order after overrun", v, 32'(8'h40 + i));
    end

    // R2 disabled FIFOs ignore traffic and raise nothing
    regWrite(3'd0, 32'h0);
    regWrite(3'd3, 32'h0000_007F);
    regWrite(3'd5, 32'h0000_0055);
    rxPush(8'h66);
    txPop(b);
    regRead(3'd4, v); check("R2 disabled fifos stay empty", v, 32'h0100_0100);
    regRead(3'd3, v); check("R2 disabled no causes", v, 32'h0);

    // R9 trailing timer: rx trig 4, limit 5, one byte waiting
    regWrite(3'd0, 32'h0000_0041);
    regWrite(3'd1, 32'h0000_0005);
    regWrite(3'd3, 32'h0000_007F);
    regWrite(3'd2, 32'h0000_0040);
    rxPush(8'h99);
    idle(3);
    irqSample(q); check("R9 trailing not before limit", {31'b0, q}, 32'h0);
    idle(2);
    irqSample(q); check("R9 trailing irq after limit", {31'b0, q}, 32'h1);
    regRead(3'd3, v); check("R9 trailing status bit6", v, 32'h40);
    regRead(3'd6, v); check("R3 trailing byte readable", v, 32'h99);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule